// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Instruction Cache

This block is a read-only instruction cache. It is 4-way set-associative, holds 16 KB in 64-byte lines and so has 64 sets. All of the set index and the word offset lie inside the 4 KB page offset. The page offset is the same in the virtual and the physical address, so the tag and data arrays are read from the untranslated address in the cycle the fetch is accepted. The physical page number arrives from an external translation unit one cycle later. It is compared with the stored physical tags of the selected set.

On a hit, the addressed 32-bit word comes back one cycle after the page number. On a miss, the cache issues one line-aligned burst read of 16 words. It writes the beats into a victim way, records the tag and then returns the requested word. An invalidate command clears the whole cache, one set per clock. The cache holds no dirty state, so nothing is ever written back.

A parameter set whose index plus offset does not exactly fill the page offset is rejected at elaboration. Extra index bits would allow synonyms: at 64 KB there would be two such bits and four page colours.

Top module: `icache_vipt`

## Requirements
- R1: Out of reset, `req_ready_o` is high and both `rsp_valid_o` and `mem_req_valid_o` are low. Every line is invalid, so the first fetch to any address misses.
- R2: A fetch is accepted in a cycle where `req_valid_i` and `req_ready_o` are both high. `req_vidx_i[9:4]` selects the set and `req_vidx_i[3:0]` selects the 32-bit word in the line. `ppn_i` is sampled only in the next cycle. On a hit, `rsp_valid_o` is high for exactly one cycle, in the cycle after that, and `rsp_data_o` carries the addressed word.
- R3: A hit issues no memory request.
- R4: A miss issues exactly one memory request at byte address `{ppn, set, 6'b0}`. Beat k of the burst is stored as word k of the line.
- R5: On a miss, `rsp_valid_o` rises in the cycle after the sixteenth beat and carries the requested word. `req_ready_o` is high in that same cycle.
- R6: Lines are told apart by the 20-bit physical page number. Up to four lines with the same set index and different page numbers are resident together.
- R7: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way given by that set's round-robin pointer, and the pointer then moves to the next way.
- R8: When `inv_i` is seen in the idle state, `req_ready_o` stays low for 64 cycles after the command is taken. Afterwards every line is invalid.
- R9: If `inv_i` and `req_valid_i` are high in the same idle cycle, the invalidation wins. The fetch is not accepted in that cycle.
- R10: From the acceptance of a fetch until its response, `req_ready_o` is low.
- R11: `mem_req_valid_o` and `mem_addr_o` hold steady until `mem_req_ready_i`. The burst may contain idle cycles between beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request |
| req_ready_o | output | 1 | Fetch can be accepted |
| req_vidx_i | input | 10 | Page-offset word address: set in [9:4], word in [3:0] |
| ppn_i | input | 20 | Physical page number, valid the cycle after acceptance |
| inv_i | input | 1 | Invalidate-all command |
| rsp_valid_o | output | 1 | Fetched word valid |
| rsp_data_o | output | 32 | Fetched word |
| mem_req_valid_o | output | 1 | Line read request |
| mem_req_ready_i | input | 1 | Line read request taken |
| mem_addr_o | output | 32 | Line base byte address |
| mem_rvalid_i | input | 1 | Burst beat valid |
| mem_rdata_i | input | 32 | Burst beat data |

## Verification
The assertions assume a memory that returns exactly 16 beats for each request, and only after the request has been taken. They also assume the translation unit presents the page number in the one cycle that follows acceptance. The bench meets both. Its memory model answers every request with one full burst, after an optional stall, and it only raises beats once the request is taken. Fetches are driven one at a time: the bench waits for `req_ready_o`, and then drives `ppn_i` only in the next cycle, with its inverse on the following cycle. A lookup that samples at the wrong time therefore returns the wrong word.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_BEAT,
    ST_INV
  } ic_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int IDX_BITS = $clog2(SETS),
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_en_i,
  input  logic [IDX_BITS-1:0]        rd_idx_i,
  output logic [WAYS-1:0]            rd_vld_o,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag_o,
  input  logic                       wr_en_i,
  input  logic [IDX_BITS-1:0]        wr_idx_i,
  input  logic [WAY_BITS-1:0]        wr_way_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  input  logic                       clr_en_i,
  input  logic [IDX_BITS-1:0]        clr_idx_i
);
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      rd_vld_o <= '0;
    end else begin
      if (clr_en_i) vld_q[clr_idx_i] <= '0;
      else if (wr_en_i) vld_q[wr_idx_i][wr_way_i] <= 1'b1;
      if (rd_en_i) rd_vld_o <= vld_q[rd_idx_i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i][wr_way_i] <= wr_tag_i;
    if (rd_en_i) rd_tag_o <= tag_q[rd_idx_i];
  end
endmodule

// File: rtl/icache_victim.sv
module icache_victim #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int IDX_BITS = $clog2(SETS),
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_BITS-1:0] idx_i,
  input  logic [WAYS-1:0]     vld_i,
  output logic [WAY_BITS-1:0] way_o,
  output logic                use_rr_o,
  input  logic                adv_i,
  input  logic [IDX_BITS-1:0] adv_idx_i
);
  logic [WAY_BITS-1:0] rr_q [SETS];

  // lowest invalid way wins; otherwise the set's pointer
  always_comb begin
    way_o    = rr_q[idx_i];
    use_rr_o = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) begin
        way_o    = WAY_BITS'(w);
        use_rr_o = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (adv_i) begin
      rr_q[adv_idx_i] <= rr_q[adv_idx_i] + WAY_BITS'(1);
    end
  end
endmodule

// File: rtl/icache_data_way.sv
module icache_data_way #(
  parameter int DEPTH  = 1024,
  parameter int WORD_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/icache_vipt.sv
module icache_vipt
  import icache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int LINE_BYTES  = 64,
  parameter int WAYS        = 4,
  parameter int CACHE_BYTES = 16384,
  localparam int OFF_BITS   = $clog2(LINE_BYTES),
  localparam int BYTE_SEL   = $clog2(WORD_W / 8),
  localparam int LINE_WORDS = LINE_BYTES / (WORD_W / 8),
  localparam int WOFF_BITS  = $clog2(LINE_WORDS),
  localparam int SETS       = CACHE_BYTES / (LINE_BYTES * WAYS),
  localparam int IDX_BITS   = $clog2(SETS),
  localparam int WAY_BITS   = $clog2(WAYS),
  localparam int TAG_W      = ADDR_W - PAGE_BITS,
  localparam int VA_W       = PAGE_BITS - BYTE_SEL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vidx_i,
  input  logic [TAG_W-1:0]  ppn_i,
  input  logic              inv_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  // index + offset must fill the page offset exactly: more bits would allow synonyms
  if (IDX_BITS + OFF_BITS != PAGE_BITS) begin : g_cfg_err
    $error("icache_vipt: set index and line offset must span exactly the page offset");
  end

  ic_state_e state_q;
  logic [IDX_BITS-1:0]  idx_q, inv_cnt_q;
  logic [WOFF_BITS-1:0] woff_q, beat_q;
  logic [TAG_W-1:0]     ppn_q;
  logic [WAY_BITS-1:0]  vict_q;
  logic                 vict_rr_q;

  logic                       acc;
  logic [WAYS-1:0]            rd_vld;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][WORD_W-1:0] rd_data;
  logic [WAYS-1:0]            hit_vec;
  logic                       hit;
  logic [WORD_W-1:0]          hit_data;
  logic [WAY_BITS-1:0]        vic_way;
  logic                       vic_rr;
  logic                       beat_en, last_beat, fill_done;

  assign req_ready_o     = (state_q == ST_IDLE) && !inv_i;
  assign acc             = req_valid_i && req_ready_o;
  assign mem_req_valid_o = (state_q == ST_MREQ);
  assign mem_addr_o      = {ppn_q, idx_q, {OFF_BITS{1'b0}}};
  assign beat_en         = (state_q == ST_BEAT) && mem_rvalid_i;
  assign last_beat       = (beat_q == WOFF_BITS'(LINE_WORDS - 1));
  assign fill_done       = beat_en && last_beat;

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = rd_vld[w] && (rd_tag[w] == ppn_i);
      hit_data   = hit_data | (rd_data[w] & {WORD_W{hit_vec[w]}});
    end
    hit = |hit_vec;
  end

  icache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (acc),
    .rd_idx_i  (req_vidx_i[WOFF_BITS +: IDX_BITS]),
    .rd_vld_o  (rd_vld),
    .rd_tag_o  (rd_tag),
    .wr_en_i   (fill_done),
    .wr_idx_i  (idx_q),
    .wr_way_i  (vict_q),
    .wr_tag_i  (ppn_q),
    .clr_en_i  (state_q == ST_INV),
    .clr_idx_i (inv_cnt_q)
  );

  icache_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx_q),
    .vld_i     (rd_vld),
    .way_o     (vic_way),
    .use_rr_o  (vic_rr),
    .adv_i     (fill_done && vict_rr_q),
    .adv_idx_i (idx_q)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    icache_data_way #(.DEPTH(SETS * LINE_WORDS), .WORD_W(WORD_W)) u_data (
      .clk_i     (clk_i),
      .rd_en_i   (acc),
      .rd_addr_i (req_vidx_i),
      .rd_data_o (rd_data[w]),
      .wr_en_i   (beat_en && (vict_q == WAY_BITS'(w))),
      .wr_addr_i ({idx_q, beat_q}),
      .wr_data_i (mem_rdata_i)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      woff_q      <= '0;
      beat_q      <= '0;
      ppn_q       <= '0;
      vict_q      <= '0;
      vict_rr_q   <= 1'b0;
      inv_cnt_q   <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (inv_i) begin
            state_q   <= ST_INV;
            inv_cnt_q <= '0;
          end else if (acc) begin
            state_q <= ST_LOOK;
            idx_q   <= req_vidx_i[WOFF_BITS +: IDX_BITS];
            woff_q  <= req_vidx_i[WOFF_BITS-1:0];
          end
        end
        ST_LOOK: begin
          if (hit) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= hit_data;
            state_q     <= ST_IDLE;
          end else begin
            ppn_q     <= ppn_i;
            vict_q    <= vic_way;
            vict_rr_q <= vic_rr;
            beat_q    <= '0;
            state_q   <= ST_MREQ;
          end
        end
        ST_MREQ: begin
          if (mem_req_ready_i) state_q <= ST_BEAT;
        end
        ST_BEAT: begin
          if (mem_rvalid_i) begin
            if (beat_q == woff_q) rsp_data_o <= mem_rdata_i;
            beat_q <= beat_q + WOFF_BITS'(1);
            if (last_beat) begin
              rsp_valid_o <= 1'b1;
              state_q     <= ST_IDLE;
            end
          end
        end
        ST_INV: begin
          inv_cnt_q <= inv_cnt_q + IDX_BITS'(1);
          if (inv_cnt_q == IDX_BITS'(SETS - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icache_vipt_chk.sv
module icache_vipt_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFF_BITS  = $clog2(LINE_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              inv_i,
  input logic              rsp_valid_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o
);
  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r2_no_rsp_in_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !rsp_valid_o);

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r5_ready_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (req_ready_o || inv_i));

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  a_r4_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_addr_o[OFF_BITS-1:0] == '0));

  a_r3_idle_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o);

  a_r9_inv_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |-> !req_ready_o);
endmodule

bind icache_vipt icache_vipt_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/icache_vipt_test.sv
module icache_vipt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [9:0]  req_vidx = '0;
  logic [19:0] ppn = '0;
  logic        inv = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_vec = 0, n_bad = 0, n_memreq = 0;
  logic [31:0] last_base = '0;
  bit stall = 1'b0;

  bit         e_vld [64][4];
  logic [19:0] e_tag [64][4];
  int         e_rr  [64];

  always #2 clk = ~clk;

  icache_vipt uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vidx_i(req_vidx),
    .ppn_i(ppn), .inv_i(inv),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] fword(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
  endfunction

  function automatic logic [19:0] pnum(input int t, input int s);
    return 20'((t << 17) ^ (s * 53 + 1));
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // memory: one 16-beat burst per request, optional stalls (R11)
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        last_base = mem_addr;
        n_memreq++;
        if (stall) repeat (2) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int b = 0; b < 16; b++) begin
          if (stall && (b % 3 == 1)) @(negedge clk);
          mem_rvalid = 1'b1;
          mem_rdata  = fword(last_base + 32'(b * 4));
          @(negedge clk);
          mem_rvalid = 1'b0;
        end
      end
    end
  end

  task automatic clear_model();
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 4; w++) e_vld[s][w] = 1'b0;
  endtask

  task automatic lookup(input logic [19:0] p, input int s, input int w, input string rq);
    int hw, m0, wait_n, early;
    logic [31:0] exp;
    hw = -1;
    for (int k = 0; k < 4; k++) if (e_vld[s][k] && e_tag[s][k] == p) hw = k;
    exp = fword({p, 6'(s), 4'(w), 2'b00});
    @(negedge clk);
    wait_n = 0;
    while (!req_ready && wait_n < 300) begin @(negedge clk); wait_n++; end
    req_valid = 1'b1;
    req_vidx  = {6'(s), 4'(w)};
    @(negedge clk);
    req_valid = 1'b0;
    ppn = p;
    m0 = n_memreq;
    @(negedge clk);
    ppn = ~p;
    if (hw >= 0) begin
      chk(rsp_valid === 1'b1, {"R2 hit latency ", rq}, 32'(rsp_valid), 1);
      chk(rsp_data === exp, {"R2 hit data ", rq}, rsp_data, exp);
      @(negedge clk);
      chk(n_memreq == m0, {"R3 no fetch on hit ", rq}, n_memreq - m0, 0);
    end else begin
      chk(rsp_valid === 1'b0, {"R4 miss no early rsp ", rq}, 32'(rsp_valid), 0);
      early = 0;
      wait_n = 0;
      while (rsp_valid !== 1'b1 && wait_n < 300) begin
        if (req_ready) early++;
        @(negedge clk);
        wait_n++;
      end
      chk(early == 0, {"R10 busy during miss ", rq}, early, 0);
      chk(n_memreq == m0 + 1, {"R4 one burst ", rq}, n_memreq - m0, 1);
      chk(last_base == {p, 6'(s), 6'b0}, {"R4 burst address ", rq}, last_base, {p, 6'(s), 6'b0});
      chk(rsp_data === exp, {"R5 miss data ", rq}, rsp_data, exp);
      chk(req_ready === 1'b1, {"R5 ready with rsp ", rq}, 32'(req_ready), 1);
      // R7: model of victim choice
      hw = -1;
      for (int k = 3; k >= 0; k--) if (!e_vld[s][k]) hw = k;
      if (hw < 0) begin
        hw = e_rr[s];
        e_rr[s] = (e_rr[s] + 1) % 4;
      end
      e_vld[s][hw] = 1'b1;
      e_tag[s][hw] = p;
    end
  endtask

  task automatic inv_window(input bit with_req, input string rq);
    int lows, rsps, m0;
    @(negedge clk);
    m0 = n_memreq;
    inv = 1'b1;
    req_valid = with_req;
    req_vidx = 10'h3F5;
    #1;
    if (with_req) chk(req_ready === 1'b0, {"R9 fetch refused ", rq}, 32'(req_ready), 0);
    @(negedge clk);
    inv = 1'b0;
    req_valid = 1'b0;
    lows = 0;
    rsps = 0;
    while (!req_ready && lows < 300) begin
      if (rsp_valid) rsps++;
      @(negedge clk);
      lows++;
    end
    chk(lows == 64, {"R8 clear window ", rq}, lows, 64);
    chk(rsps == 0 && n_memreq == m0, {"R9 no fetch activity ", rq}, rsps + n_memreq - m0, 0);
    clear_model();
  endtask

  initial begin
    clear_model();
    for (int s = 0; s < 64; s++) e_rr[s] = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1 outputs in reset",
        {30'b0, rsp_valid, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1 idle after reset",
        {30'b0, rsp_valid, mem_req_valid}, 0);

    // R1/R6: fill every way of every set with distinct page numbers
    for (int s = 0; s < 64; s++)
      for (int t = 0; t < 4; t++) lookup(pnum(t, s), s, (s + t) % 16, "R1 R6 fill");
    // R2/R6: every word of every resident line hits
    for (int s = 0; s < 64; s++)
      for (int t = 0; t < 4; t++)
        for (int w = 0; w < 16; w++) lookup(pnum(t, s), s, w, "R6 sweep");

    // R7: replacement order on a few sets
    foreach (e_rr[s]) if (s == 0 || s == 1 || s == 63) begin
      lookup(pnum(4, s), s, 3, "R7 a");
      lookup(pnum(0, s), s, 4, "R7 b");
      lookup(pnum(5, s), s, 5, "R7 c");
      lookup(pnum(1, s), s, 6, "R7 d");
      lookup(pnum(6, s), s, 7, "R7 e");
      lookup(pnum(7, s), s, 8, "R7 f");
      lookup(pnum(2, s), s, 9, "R7 g");
      lookup(pnum(4, s), s, 10, "R7 h");
      lookup(pnum(3, s), s, 11, "R7 i");
    end

    // R11: stalled request and gapped beats, edge word offsets
    stall = 1'b1;
    lookup(pnum(6, 5), 5, 0, "R11 word 0");
    lookup(pnum(7, 5), 5, 15, "R11 word 15");
    lookup(pnum(7, 5), 5, 15, "R11 rehit");
    stall = 1'b0;

    // R8: invalidate, then resident lines miss
    inv_window(1'b0, "plain");
    lookup(pnum(7, 5), 5, 2, "R8 after clear");
    lookup(pnum(1, 40), 40, 0, "R8 after clear");
    lookup(pnum(1, 40), 40, 1, "R8 rehit");

    // R9: simultaneous fetch and invalidate
    inv_window(1'b1, "with fetch");
    lookup(pnum(1, 40), 40, 1, "R9 after clear");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule